// File: doc/BRIEF.md
# Parallel-Command Crosspoint Configuration Controller

This block is the digital control core of an 8-by-8 crosspoint router. A host presents a 7-bit word made of a 3-bit output address and a 4-bit code, then raises a write strobe. If both chip enables are asserted at that moment, the word is taken into a staging (first-rank) entry for the addressed output. A code with its top bit clear picks one of eight input channels. A code with its top bit set is a command. Commands can ground an output's buffer input, switch one buffer or all buffers off or on, or copy the whole staging rank to the live rank.

The live (second-rank) registers drive the routing controls for each output: a 3-bit input select, a ground flag and a buffer enable. The live rank is refreshed from the staging rank in one of three ways. In edge mode it loads on a rising edge of the latch input. In level mode it follows the staging rank while the latch input is low. Some commands also load it. Because of this, several outputs can be staged one after another and then switched together in a single clock cycle. The write strobe and the latch input are asynchronous. Each passes through a two-flop synchronizer into the system clock domain, where its edges are detected.

Top module: `xpoint_ctrl`

## Requirements
- R1: A word is captured into the staging entry for `addr` once, on the rising edge of `wr_strobe`. It becomes visible on the routing outputs only when the live rank is loaded.
- R2: A write is acted on only when `cs_n` is 0 and `cs` is 1 at the strobe's rising edge. Any other combination leaves every output and the staging rank unchanged.
- R3: Codes 0000 to 0111 stage input channel `code[2:0]` for the addressed output and clear its ground flag. Code 1000 sets the addressed output's ground flag and keeps its staged channel. Output i's select appears on `route_sel[3i+2:3i]` and its ground flag on `route_gnd[i]`.
- R4: Code 1011 clears `route_en[addr]` and code 1100 sets it. Neither command changes any stored channel or ground flag.
- R5: Code 1101 clears every bit of `route_en` and code 1110 sets every bit. Neither changes the stored routing.
- R6: Running any of the codes 1011, 1100, 1101 or 1110 also copies the whole staging rank into the live rank.
- R7: Code 1111 copies the staging rank into the live rank when `latch_in` is high. When `latch_in` is low it does nothing.
- R8: With `edge_mode` = 1, the live rank loads on each rising edge of `latch_in` and holds at all other times.
- R9: With `edge_mode` = 0, the live rank follows the staging rank while `latch_in` is low and holds while it is high.
- R10: Codes 1001 and 1010 have no effect on any output or on the staging rank.
- R11: After reset, every bit of `route_en` is 0.
- R12: When several outputs have been staged before one latch edge, all of their new selects appear on the routing outputs in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_strobe | input | 1 | Asynchronous write strobe; its rising edge captures the word |
| cs_n | input | 1 | Active-low chip enable qualifying writes |
| cs | input | 1 | Active-high chip enable qualifying writes |
| addr | input | 3 | Output address of the word |
| code | input | 4 | Channel select (top bit 0) or command (top bit 1) |
| latch_in | input | 1 | Asynchronous latch control for the live rank |
| edge_mode | input | 1 | 1: live rank loads on latch rising edge; 0: transparent while latch low |
| route_sel | output | 24 | Live input select per output, 3 bits each |
| route_gnd | output | 8 | Live ground flag per output |
| route_en | output | 8 | Buffer enable per output |

## Verification
Directed sequences in edge mode stage three outputs while the latch is low. They confirm that nothing moves before the latch edge and that all three selects change in the same cycle after it. This separates correct double-buffering from a design that routes writes straight through. Further directed writes cover the following:
- each command code, applied with an enable pattern on and off;
- the software latch with the latch input both low and high;
- the reserved codes;
- a switch into level mode.

These tell apart commands that must reload the live rank from commands that must not. A seeded random walk then mixes channel writes, every command code, mode changes, latch toggles and enable combinations, and compares against a bench model. This exposes ordering interactions, such as a level-mode transparent window following an edge-mode latch.

// File: rtl/xpc_pkg.sv
package xpc_pkg;

    // command field values (low bits of a code whose top bit is set)
    localparam logic [2:0] OP_GROUND  = 3'b000;
    localparam logic [2:0] OP_RSVD_A  = 3'b001;
    localparam logic [2:0] OP_RSVD_B  = 3'b010;
    localparam logic [2:0] OP_OFF_ONE = 3'b011;
    localparam logic [2:0] OP_ON_ONE  = 3'b100;
    localparam logic [2:0] OP_OFF_ALL = 3'b101;
    localparam logic [2:0] OP_ON_ALL  = 3'b110;
    localparam logic [2:0] OP_SW_LAT  = 3'b111;

    typedef struct packed {
        logic route;     // stage a channel select
        logic ground;    // set staged ground flag
        logic off_one;
        logic on_one;
        logic off_all;
        logic on_all;
        logic sw_latch;  // software latch request
        logic cmd_load;  // command forces a live-rank load
    } xpc_op_t;

endpackage

// File: rtl/xpc_sync.sv
module xpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] sh_d, sh_q;
    logic              prev_d, prev_q;

    always_comb begin
        sh_d   = {sh_q[STAGES-2:0], async_in};
        prev_d = sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/xpc_decode.sv
module xpc_decode #(
    parameter int SEL_W = 3
) (
    input  logic             fire,
    input  logic [SEL_W:0]   code,
    output xpc_pkg::xpc_op_t op
);
    import xpc_pkg::*;

    logic [SEL_W-1:0] field;
    assign field = code[SEL_W-1:0];

    always_comb begin
        op = '0;
        if (fire) begin
            if (!code[SEL_W]) begin
                op.route = 1'b1;
            end else begin
                unique case (field)
                    SEL_W'(OP_GROUND):  op.ground = 1'b1;
                    SEL_W'(OP_OFF_ONE): begin op.off_one = 1'b1; op.cmd_load = 1'b1; end
                    SEL_W'(OP_ON_ONE):  begin op.on_one  = 1'b1; op.cmd_load = 1'b1; end
                    SEL_W'(OP_OFF_ALL): begin op.off_all = 1'b1; op.cmd_load = 1'b1; end
                    SEL_W'(OP_ON_ALL):  begin op.on_all  = 1'b1; op.cmd_load = 1'b1; end
                    SEL_W'(OP_SW_LAT):  op.sw_latch = 1'b1;
                    default:            op = '0;   // reserved codes
                endcase
            end
        end
    end
endmodule

// File: rtl/xpc_ranks.sv
module xpc_ranks #(
    parameter int N_OUT  = 8,
    parameter int SEL_W  = 3,
    parameter int ADDR_W = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  xpc_pkg::xpc_op_t                 op,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [SEL_W-1:0]                 chan,
    input  logic                             edge_mode,
    input  logic                             latch_lvl,
    input  logic                             latch_rise,
    output logic [N_OUT-1:0][SEL_W-1:0]      live_sel,
    output logic [N_OUT-1:0]                 live_gnd,
    output logic [N_OUT-1:0]                 live_en,
    output logic                             load
);
    typedef struct packed {
        logic [N_OUT-1:0][SEL_W-1:0] stg_sel;
        logic [N_OUT-1:0]            stg_gnd;
        logic [N_OUT-1:0][SEL_W-1:0] act_sel;
        logic [N_OUT-1:0]            act_gnd;
        logic [N_OUT-1:0]            en;
    } rank_st_t;

    rank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        load = op.cmd_load
             | (op.sw_latch & latch_lvl)
             | (edge_mode ? latch_rise : ~latch_lvl);

        if (op.route) begin
            st_d.stg_sel[addr] = chan;
            st_d.stg_gnd[addr] = 1'b0;
        end
        if (op.ground)  st_d.stg_gnd[addr] = 1'b1;
        if (op.off_one) st_d.en[addr] = 1'b0;
        if (op.on_one)  st_d.en[addr] = 1'b1;
        if (op.off_all) st_d.en = '0;
        if (op.on_all)  st_d.en = '1;

        if (load) begin
            st_d.act_sel = st_q.stg_sel;
            st_d.act_gnd = st_q.stg_gnd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_sel = st_q.act_sel;
    assign live_gnd = st_q.act_gnd;
    assign live_en  = st_q.en;
endmodule

// File: rtl/xpoint_ctrl.sv
module xpoint_ctrl #(
    parameter int N_OUT       = 8,
    parameter int N_IN        = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W  = $clog2(N_IN),
    localparam int ADDR_W = $clog2(N_OUT),
    localparam int CODE_W = SEL_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_strobe,
    input  logic                    cs_n,
    input  logic                    cs,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [CODE_W-1:0]       code,
    input  logic                    latch_in,
    input  logic                    edge_mode,
    output logic [N_OUT*SEL_W-1:0]  route_sel,
    output logic [N_OUT-1:0]        route_gnd,
    output logic [N_OUT-1:0]        route_en
);
    logic             wr_lvl, wr_rise, lat_lvl, lat_rise;
    logic             wr_fire, load_w;
    xpc_pkg::xpc_op_t op_w;
    logic [N_OUT-1:0][SEL_W-1:0] sel_w;

    xpc_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .async_in(wr_strobe),
        .level(wr_lvl), .rise(wr_rise)
    );

    xpc_sync #(.STAGES(SYNC_STAGES)) u_lat_sync (
        .clk(clk), .rst_n(rst_n), .async_in(latch_in),
        .level(lat_lvl), .rise(lat_rise)
    );

    // both chip enables must be active at the strobe edge
    assign wr_fire = wr_rise & ~cs_n & cs;

    xpc_decode #(.SEL_W(SEL_W)) u_dec (
        .fire(wr_fire), .code(code), .op(op_w)
    );

    xpc_ranks #(.N_OUT(N_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_ranks (
        .clk(clk), .rst_n(rst_n), .op(op_w), .addr(addr),
        .chan(code[SEL_W-1:0]), .edge_mode(edge_mode),
        .latch_lvl(lat_lvl), .latch_rise(lat_rise),
        .live_sel(sel_w), .live_gnd(route_gnd), .live_en(route_en),
        .load(load_w)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_flat
        assign route_sel[i*SEL_W +: SEL_W] = sel_w[i];
    end

    logic unused_w;
    assign unused_w = wr_lvl;
endmodule

// File: rtl/xpoint_ctrl_chk.sv
module xpoint_ctrl_chk #(
    parameter int N_OUT = 8,
    parameter int SEL_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_fire,
    input logic [SEL_W:0]         code,
    input logic                   load_w,
    input logic [N_OUT*SEL_W-1:0] route_sel,
    input logic [N_OUT-1:0]       route_gnd,
    input logic [N_OUT-1:0]       route_en
);
    logic is_cmd;
    assign is_cmd = wr_fire & code[SEL_W];

    // R11
    reset_en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> route_en == '0);

    // R8 R9 R12
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_w |=> ($stable(route_sel) && $stable(route_gnd)));

    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(route_en));

    // R10
    reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && (code[SEL_W-1:0] == SEL_W'(1) || code[SEL_W-1:0] == SEL_W'(2)))
        |=> $stable(route_en));

    // R5
    all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && code[SEL_W-1:0] == SEL_W'(6)) |=> route_en == '1);

    // R5
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && code[SEL_W-1:0] == SEL_W'(5)) |=> route_en == '0);

    // R6
    cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && code[SEL_W-1:0] >= SEL_W'(3) && code[SEL_W-1:0] <= SEL_W'(6))
        |-> load_w);
endmodule

bind xpoint_ctrl xpoint_ctrl_chk #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .code(code),
    .load_w(load_w), .route_sel(route_sel), .route_gnd(route_gnd),
    .route_en(route_en)
);

// File: tb/xpoint_ctrl_test.sv
module xpoint_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_strobe = 1'b0, cs_n = 1'b0, cs = 1'b1;
    logic [2:0]  addr = '0;
    logic [3:0]  code = '0;
    logic        latch_in = 1'b0, edge_mode = 1'b1;
    logic [23:0] route_sel;
    logic [7:0]  route_gnd, route_en;

    int n_cmp = 0, n_bad = 0;

    // bench model
    logic [2:0] m_sel1 [8];
    logic       m_gnd1 [8];
    logic [2:0] m_sel2 [8];
    logic       m_gnd2 [8];
    logic [7:0] m_en;

    always #2 clk = ~clk;

    xpoint_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .cs_n(cs_n), .cs(cs),
        .addr(addr), .code(code), .latch_in(latch_in), .edge_mode(edge_mode),
        .route_sel(route_sel), .route_gnd(route_gnd), .route_en(route_en)
    );

    function automatic void m_load();
        for (int i = 0; i < 8; i++) begin
            m_sel2[i] = m_sel1[i];
            m_gnd2[i] = m_gnd1[i];
        end
    endfunction

    function automatic void m_settle();
        if (!edge_mode && !latch_in) m_load();
    endfunction

    function automatic void m_write(int a, logic [3:0] c, logic cn, logic c1);
        if (cn || !c1) return;
        if (!c[3]) begin
            m_sel1[a] = c[2:0];
            m_gnd1[a] = 1'b0;
        end else begin
            case (c[2:0])
                3'd0: m_gnd1[a] = 1'b1;
                3'd3: begin m_en[a] = 1'b0; m_load(); end
                3'd4: begin m_en[a] = 1'b1; m_load(); end
                3'd5: begin m_en = '0; m_load(); end
                3'd6: begin m_en = '1; m_load(); end
                3'd7: if (latch_in) m_load();
                default: ;
            endcase
        end
    endfunction

    function automatic logic [23:0] exp_sel();
        logic [23:0] v;
        for (int i = 0; i < 8; i++) v[i*3 +: 3] = m_sel2[i];
        return v;
    endfunction

    function automatic logic [7:0] exp_gnd();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = m_gnd2[i];
        return v;
    endfunction

    function automatic string req_of(logic [3:0] c, logic ok);
        if (!ok) return "R2";
        if (!c[3] || c[2:0] == 3'd0) return "R3";
        case (c[2:0])
            3'd1, 3'd2: return "R10";
            3'd3, 3'd4: return "R4";
            3'd5, 3'd6: return "R5";
            default:    return "R7";
        endcase
    endfunction

    task automatic check_out(string tag);
        n_cmp += 3;
        if (route_sel !== exp_sel()) begin
            n_bad++;
            $display("FAIL %s route_sel actual=%h expected=%h", tag, route_sel, exp_sel());
        end
        if (route_gnd !== exp_gnd()) begin
            n_bad++;
            $display("FAIL %s route_gnd actual=%b expected=%b", tag, route_gnd, exp_gnd());
        end
        if (route_en !== m_en) begin
            n_bad++;
            $display("FAIL %s route_en actual=%b expected=%b", tag, route_en, m_en);
        end
    endtask

    task automatic do_write(int a, logic [3:0] c, logic cn, logic c1);
        @(negedge clk);
        addr = 3'(a); code = c; cs_n = cn; cs = c1; wr_strobe = 1'b1;
        repeat (6) @(negedge clk);
        wr_strobe = 1'b0;
        repeat (3) @(negedge clk);
        m_write(a, c, cn, c1);
        m_settle();
    endtask

    task automatic set_latch(logic v);
        logic was;
        was = latch_in;
        @(negedge clk);
        latch_in = v;
        repeat (6) @(negedge clk);
        if (edge_mode && v && !was) m_load();
        m_settle();
    endtask

    task automatic set_mode(logic m);
        @(negedge clk);
        edge_mode = m;
        repeat (4) @(negedge clk);
        m_settle();
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 8; i++) begin
            m_sel1[i] = '0; m_gnd1[i] = 1'b0; m_sel2[i] = '0; m_gnd2[i] = 1'b0;
        end
        m_en = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11: reset state of enables
        n_cmp++;
        if (route_en !== 8'h00) begin
            n_bad++;
            $display("FAIL R11 route_en actual=%b expected=%b", route_en, 8'h00);
        end

        // R1 R8: staged writes in edge mode, not yet visible
        do_write(0, 4'd5, 1'b0, 1'b1);
        do_write(1, 4'd2, 1'b0, 1'b1);
        do_write(7, 4'd7, 1'b0, 1'b1);
        check_out("R1");

        // R12: all staged outputs change in the same cycle
        begin
            logic [23:0] old_sel;
            int waited = 0;
            old_sel = route_sel;
            @(negedge clk);
            latch_in = 1'b1;
            while (route_sel === old_sel && waited < 20) begin
                @(negedge clk);
                waited++;
            end
            m_load();
            n_cmp++;
            if (route_sel !== exp_sel()) begin
                n_bad++;
                $display("FAIL R12 route_sel actual=%h expected=%h", route_sel, exp_sel());
            end
            repeat (4) @(negedge clk);
            set_latch(1'b0);
            check_out("R8");
        end

        // R5 R6: enable all, also reloads live rank
        do_write(2, 4'd4, 1'b0, 1'b1);
        do_write(0, 4'b1110, 1'b0, 1'b1);
        check_out("R5");
        check_out("R6");

        // R4: single off/on keeps routing
        do_write(1, 4'b1011, 1'b0, 1'b1);
        check_out("R4");
        do_write(1, 4'b1100, 1'b0, 1'b1);
        check_out("R4");

        // R3: ground flag
        do_write(3, 4'b1000, 1'b0, 1'b1);
        set_latch(1'b1);
        set_latch(1'b0);
        check_out("R3");

        // R10: reserved codes, observe after a latch
        do_write(0, 4'b1001, 1'b0, 1'b1);
        do_write(5, 4'b1010, 1'b0, 1'b1);
        check_out("R10");
        set_latch(1'b1);
        set_latch(1'b0);
        check_out("R10");

        // R2: disqualified writes
        do_write(0, 4'b1101, 1'b1, 1'b1);
        do_write(4, 4'd6, 1'b0, 1'b0);
        do_write(4, 4'b1101, 1'b1, 1'b0);
        check_out("R2");
        set_latch(1'b1);
        set_latch(1'b0);
        check_out("R2");

        // R7: software latch with latch low: nothing
        do_write(6, 4'd3, 1'b0, 1'b1);
        do_write(6, 4'b1111, 1'b0, 1'b1);
        check_out("R7");
        // R7: software latch with latch high
        set_latch(1'b1);
        do_write(2, 4'd1, 1'b0, 1'b1);
        check_out("R8");
        do_write(0, 4'b1111, 1'b0, 1'b1);
        check_out("R7");

        // R9: level mode
        set_mode(1'b0);
        do_write(5, 4'd6, 1'b0, 1'b1);
        check_out("R9");
        set_latch(1'b0);
        check_out("R9");
        do_write(4, 4'd3, 1'b0, 1'b1);
        check_out("R9");
        set_mode(1'b1);

        // random walk
        for (int s = 0; s < 300; s++) begin
            int r;
            r = $urandom_range(0, 11);
            if (r == 9) begin
                set_latch(~latch_in);
                check_out(edge_mode ? "R8" : "R9");
            end else if (r == 10) begin
                set_mode(~edge_mode);
                check_out("R9");
            end else begin
                int a;
                logic [3:0] c;
                logic cn, c1;
                a  = $urandom_range(0, 7);
                c  = 4'($urandom_range(0, 15));
                cn = ($urandom_range(0, 5) == 0);
                c1 = ($urandom_range(0, 5) != 0);
                do_write(a, c, cn, c1);
                check_out(req_of(c, !cn && c1));
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule